// File: doc/BRIEF.md
# Character-Serial I/O Buffer with Parity

This block moves 6-bit characters, each with one parity bit, between a processor-side buffer and an external device. The device paces every transfer with its own strobe. The strobe is brought into the system clock domain and only its rising edge is used. In receive mode, each accepted strobe edge latches the device's data lines and parity bit into a one-character buffer. The block then checks parity as even or odd and raises a read-acknowledge pulse back to the device. In send mode, the processor deposits a character. The next strobe edge drives it onto the output lines together with a generated parity bit.

A buffer-ready output tells both sides whether a character can be exchanged. A last-character input, when it is high during an accepted transfer, sets a disconnect flip-flop. While this flip-flop is set, the output lines are forced low and further transfers are refused until a new record begins. A start input clears the whole block. A sticky parity-error flag records any bad received character until start or the beginning of the next record.

Data bit 0 is the least significant bit of a character. Bit CHAR_W-1 is the most significant.

Top module: `chio_buffer`

## Requirements
- R1: After reset or a one-cycle `start`, `read_ack`, `par_err`, `disc`, `out_data` and `out_par` are 0 and `buf_rdy` is 1.
- R2: A rising edge of `dev_clk` is acted on at the third `clk` edge after it (SYNC_STAGES=2 plus one edge-detect stage). Keeping `dev_clk` high causes no further transfer.
- R3: In receive mode (`dir_out`=0), an accepted edge with the buffer empty copies `in_data` to `rx_char`. The buffer then becomes full (`buf_rdy`=0) until a `cpu_take` cycle. `read_ack` is high for exactly ACK_LEN (default 2) cycles starting with the capture.
- R4: In receive mode, a strobe edge while the buffer is full is ignored. `rx_char` is unchanged and `read_ack` stays 0.
- R5: Parity check: with `odd_sel`=0, the ones in `in_data` plus `in_par` must be even. With `odd_sel`=1 they must be odd. A mismatch sets `par_err` only if `no_par` is 0.
- R6: `par_err` stays set until `start` or `rec_begin`.
- R7: In send mode (`dir_out`=1), `tx_load` with an empty holding register stores `tx_data` and drops `buf_rdy`. A `tx_load` while the register is full is ignored. The next accepted strobe edge drives `out_data` with the character and `out_par` with XOR of its bits XOR `odd_sel`, and raises `buf_rdy`. A strobe edge with the register empty leaves the outputs unchanged.
- R8: An accepted transfer (a capture or a send) with `last_chr`=1 sets `disc`.
- R9: While `disc` is 1, `out_data` and `out_par` are 0 and `buf_rdy` is 0. Strobe edges and `tx_load` are ignored. `rec_begin` clears `disc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous clear of the whole block |
| rec_begin | input | 1 | New record: clears disconnect and parity error |
| dir_out | input | 1 | 1 = send mode, 0 = receive mode |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| last_chr | input | 1 | Current transfer is the record's last character |
| dev_clk | input | 1 | Asynchronous transfer strobe from the device |
| in_data | input | CHAR_W | Received character lines |
| in_par | input | 1 | Received parity bit |
| no_par | input | 1 | Device supplies no parity; skip the check |
| read_ack | output | 1 | Character has been read |
| cpu_take | input | 1 | Processor consumed `rx_char` |
| rx_char | output | CHAR_W | Last captured character |
| par_err | output | 1 | Sticky parity error |
| tx_load | input | 1 | Deposit `tx_data` for sending |
| tx_data | input | CHAR_W | Character to send |
| out_data | output | CHAR_W | Output character lines |
| out_par | output | 1 | Generated output parity |
| buf_rdy | output | 1 | Buffer can accept or supply a character |
| disc | output | 1 | Disconnected from the device |

## Verification
Every strobe-driven result (`rx_char`, `read_ack`, `par_err`, `out_data`, `out_par`, `disc`, `buf_rdy`) is due three `clk` edges after `dev_clk` rises. The bench raises the strobe on a falling clock edge and samples one time unit after each later rising edge. It checks that `read_ack` is still 0 after the second edge, is 1 after the third and fourth, and is 0 again after the fifth. Processor-side inputs (`tx_load`, `cpu_take`, `start`, `rec_begin`) take effect at the first rising edge. Their results are therefore sampled just after that edge.

// File: rtl/chio_pkg.sv
package chio_pkg;
   typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} chio_dir_e;

   function automatic logic chio_parity(input logic [31:0] bits, input int unsigned width,
                                        input logic odd);
      logic acc;
      acc = odd;
      for (int i = 0; i < 32; i++)
         if (i < int'(width)) acc = acc ^ bits[i];
      return acc;
   endfunction
endpackage

// File: rtl/chio_sync.sv
module chio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES:0] sh;

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[0] <= 1'b0;
            else        sh[0] <= async_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= sh[g-1];
      end
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/chio_parity.sv
module chio_parity #(
   parameter int W = 6
) (
   input  logic [W-1:0] data,
   input  logic         par_in,
   input  logic         odd,
   output logic         par_o
);
   // with par_in = 0 this yields the parity bit to send;
   // with the received bit it yields 1 on a mismatch
   assign par_o = chio_pkg::chio_parity(32'(data), W, odd) ^ par_in;
endmodule

// File: rtl/chio_rx.sv
module chio_rx #(
   parameter int W       = 6,
   parameter int ACK_LEN = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         xfer,
   input  logic [W-1:0] in_data,
   input  logic         in_par,
   input  logic         no_par,
   input  logic         odd_sel,
   input  logic         take,
   output logic [W-1:0] rx_char,
   output logic         rx_full,
   output logic         ack,
   output logic         perr_set,
   output logic         done
);
   localparam int ACK_CW = $clog2(ACK_LEN + 1);

   logic [ACK_CW-1:0] ack_cnt;
   logic              mism;

   chio_parity #(.W(W)) u_chk (
      .data(in_data), .par_in(in_par), .odd(odd_sel), .par_o(mism)
   );

   assign done     = xfer & ~rx_full;
   assign perr_set = done & ~no_par & mism;
   assign ack      = (ack_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_char <= '0;
         rx_full <= 1'b0;
         ack_cnt <= '0;
      end else if (start) begin
         rx_char <= '0;
         rx_full <= 1'b0;
         ack_cnt <= '0;
      end else begin
         if (done) begin
            rx_char <= in_data;
            rx_full <= 1'b1;
            ack_cnt <= ACK_CW'(ACK_LEN);
         end else begin
            if (take) rx_full <= 1'b0;
            if (ack_cnt != '0) ack_cnt <= ack_cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/chio_tx.sv
module chio_tx #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         load,
   input  logic [W-1:0] tx_data,
   input  logic         xfer,
   input  logic         odd_sel,
   output logic [W-1:0] out_reg,
   output logic         out_par,
   output logic         tx_full,
   output logic         done
);
   logic [W-1:0] hold;
   logic         gen;

   chio_parity #(.W(W)) u_gen (
      .data(hold), .par_in(1'b0), .odd(odd_sel), .par_o(gen)
   );

   assign done = xfer & tx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         tx_full <= 1'b0;
         out_reg <= '0;
         out_par <= 1'b0;
      end else if (start) begin
         hold    <= '0;
         tx_full <= 1'b0;
         out_reg <= '0;
         out_par <= 1'b0;
      end else if (done) begin
         out_reg <= hold;
         out_par <= gen;
         tx_full <= 1'b0;
      end else if (load && !tx_full) begin
         hold    <= tx_data;
         tx_full <= 1'b1;
      end
   end
endmodule

// File: rtl/chio_buffer.sv
module chio_buffer #(
   parameter int CHAR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_LEN     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rec_begin,
   input  logic              dir_out,
   input  logic              odd_sel,
   input  logic              last_chr,
   input  logic              dev_clk,
   input  logic [CHAR_W-1:0] in_data,
   input  logic              in_par,
   input  logic              no_par,
   output logic              read_ack,
   input  logic              cpu_take,
   output logic [CHAR_W-1:0] rx_char,
   output logic              par_err,
   input  logic              tx_load,
   input  logic [CHAR_W-1:0] tx_data,
   output logic [CHAR_W-1:0] out_data,
   output logic              out_par,
   output logic              buf_rdy,
   output logic              disc
);
   import chio_pkg::*;

   if (CHAR_W < 1 || CHAR_W > 32) begin : g_bad_w
      $error("chio_buffer: CHAR_W must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("chio_buffer: SYNC_STAGES must be at least 2");
   end
   if (ACK_LEN < 1) begin : g_bad_ack
      $error("chio_buffer: ACK_LEN must be at least 1");
   end

   chio_dir_e    dir;
   logic         rise, xfer_rx, xfer_tx;
   logic         rx_full, tx_full, rx_done, tx_done, perr_set, tx_par;
   logic [CHAR_W-1:0] out_reg;

   assign dir     = chio_dir_e'(dir_out);
   assign xfer_rx = rise & (dir == DIR_RX) & ~disc;
   assign xfer_tx = rise & (dir == DIR_TX) & ~disc;

   chio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(dev_clk), .rise(rise)
   );

   chio_rx #(.W(CHAR_W), .ACK_LEN(ACK_LEN)) u_rx (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer(xfer_rx),
      .in_data(in_data), .in_par(in_par), .no_par(no_par), .odd_sel(odd_sel),
      .take(cpu_take), .rx_char(rx_char), .rx_full(rx_full), .ack(read_ack),
      .perr_set(perr_set), .done(rx_done)
   );

   chio_tx #(.W(CHAR_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .load(tx_load & ~disc),
      .tx_data(tx_data), .xfer(xfer_tx), .odd_sel(odd_sel),
      .out_reg(out_reg), .out_par(tx_par), .tx_full(tx_full), .done(tx_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disc    <= 1'b0;
         par_err <= 1'b0;
      end else if (start || rec_begin) begin
         disc    <= 1'b0;
         par_err <= 1'b0;
      end else begin
         if ((rx_done || tx_done) && last_chr) disc <= 1'b1;
         if (perr_set) par_err <= 1'b1;
      end
   end

   assign out_data = disc ? '0 : out_reg;
   assign out_par  = disc ? 1'b0 : tx_par;
   assign buf_rdy  = ~disc & ((dir == DIR_TX) ? ~tx_full : ~rx_full);
endmodule

// File: rtl/chio_buffer_chk.sv
module chio_buffer_chk #(
   parameter int CHAR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              rec_begin,
   input logic              dir_out,
   input logic              last_chr,
   input logic              read_ack,
   input logic              par_err,
   input logic [CHAR_W-1:0] out_data,
   input logic              out_par,
   input logic              buf_rdy,
   input logic              disc
);
   // R9
   disc_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disc |-> (out_data == '0) && !out_par);
   // R9
   disc_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disc |-> !buf_rdy);
   // R6
   perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_err && !start && !rec_begin |=> par_err);
   // R1
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !par_err && !disc && !read_ack);
   // R3
   ack_rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(read_ack) |-> !$past(dir_out));
   // R8
   disc_from_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disc) |-> $past(last_chr));
endmodule

bind chio_buffer chio_buffer_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rec_begin(rec_begin),
   .dir_out(dir_out), .last_chr(last_chr), .read_ack(read_ack),
   .par_err(par_err), .out_data(out_data), .out_par(out_par),
   .buf_rdy(buf_rdy), .disc(disc)
);

// File: tb/chio_buffer_tb.sv
module chio_buffer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 6;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rec_begin = 1'b0;
   logic dir_out = 1'b0, odd_sel = 1'b0, last_chr = 1'b0, dev_clk = 1'b0;
   logic [W-1:0] in_data = '0, tx_data = '0;
   logic in_par = 1'b0, no_par = 1'b0, cpu_take = 1'b0, tx_load = 1'b0;
   logic read_ack, par_err, out_par, buf_rdy, disc;
   logic [W-1:0] rx_char, out_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic exp_perr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chio_buffer #(.CHAR_W(W), .SYNC_STAGES(2), .ACK_LEN(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rec_begin(rec_begin),
      .dir_out(dir_out), .odd_sel(odd_sel), .last_chr(last_chr), .dev_clk(dev_clk),
      .in_data(in_data), .in_par(in_par), .no_par(no_par), .read_ack(read_ack),
      .cpu_take(cpu_take), .rx_char(rx_char), .par_err(par_err),
      .tx_load(tx_load), .tx_data(tx_data), .out_data(out_data), .out_par(out_par),
      .buf_rdy(buf_rdy), .disc(disc)
   );

   function automatic logic f_par(input logic [W-1:0] d, input logic odd);
      return (^d) ^ odd;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // strobe edge; read_ack checked at each cycle around the due edge
   task automatic strobe(input logic exp_ack);
      @(negedge clk) dev_clk = 1'b1;
      repeat (2) @(posedge clk);
      #1 check("R2 ack not yet", 32'(read_ack), 0);
      @(posedge clk); #1 check("R3 ack cycle 1", 32'(read_ack), 32'(exp_ack));
      @(posedge clk); #1 check("R3 ack cycle 2", 32'(read_ack), 32'(exp_ack));
      @(posedge clk); #1 check("R3 ack end", 32'(read_ack), 0);
      @(negedge clk) dev_clk = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   task automatic pulse_take();
      @(negedge clk) cpu_take = 1'b1;
      @(negedge clk) cpu_take = 1'b0;
   endtask

   task automatic load(input logic [W-1:0] d);
      @(negedge clk) begin tx_load = 1'b1; tx_data = d; end
      @(negedge clk) tx_load = 1'b0;
   endtask

   task automatic one_shot(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   initial begin
      logic [W-1:0] d, held;
      logic bad;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R1 ack", 32'(read_ack), 0);
      check("R1 perr", 32'(par_err), 0);
      check("R1 disc", 32'(disc), 0);
      check("R1 out", {25'(out_data), out_par}, 0);
      check("R1 rdy", 32'(buf_rdy), 1);

      // random receive/send mix
      for (int i = 0; i < 60; i++) begin
         if ($urandom % 2 == 0) begin
            @(negedge clk);
            dir_out = 1'b0;
            d = W'($urandom); odd_sel = 1'($urandom); no_par = 1'($urandom);
            bad = ($urandom % 4 == 0);
            in_data = d; in_par = f_par(d, odd_sel) ^ bad;
            strobe(1'b1);
            if (bad && !no_par) exp_perr = 1'b1;
            check("R3 rx_char", 32'(rx_char), 32'(d));
            check("R5 par_err", 32'(par_err), 32'(exp_perr));
            check("R3 full", 32'(buf_rdy), 0);
            pulse_take();
            #1 check("R3 take", 32'(buf_rdy), 1);
         end else begin
            @(negedge clk);
            dir_out = 1'b1; odd_sel = 1'($urandom);
            d = W'($urandom);
            load(d);
            check("R7 loaded", 32'(buf_rdy), 0);
            strobe(1'b0);
            check("R7 out_data", 32'(out_data), 32'(d));
            check("R7 out_par", 32'(out_par), 32'(f_par(d, odd_sel)));
            check("R7 rdy", 32'(buf_rdy), 1);
         end
      end

      // R6: sticky flag cleared by rec_begin
      @(negedge clk) begin dir_out = 1'b0; no_par = 1'b0; odd_sel = 1'b1;
                            in_data = 6'b000011; in_par = 1'b0; end
      strobe(1'b1);
      check("R5 odd mismatch", 32'(par_err), 1);
      pulse_take();
      repeat (5) @(posedge clk);
      #1 check("R6 sticky", 32'(par_err), 1);
      one_shot(rec_begin);
      #1 check("R6 rec clears", 32'(par_err), 0);
      exp_perr = 1'b0;

      // R5: even parity, correct bit, and no_par skip
      @(negedge clk) begin odd_sel = 1'b0; in_data = 6'b101100; in_par = 1'b1; end
      strobe(1'b1);
      check("R5 even ok", 32'(par_err), 0);
      pulse_take();
      @(negedge clk) begin no_par = 1'b1; in_par = 1'b0; end
      strobe(1'b1);
      check("R5 no_par skip", 32'(par_err), 0);

      // R4: full buffer ignores a strobe
      held = rx_char;
      @(negedge clk) in_data = ~held;
      strobe(1'b0);
      check("R4 char kept", 32'(rx_char), 32'(held));
      pulse_take();

      // R2: holding dev_clk high gives one transfer only
      @(negedge clk) begin in_data = 6'h15; dev_clk = 1'b1; end
      repeat (4) @(posedge clk);
      pulse_take();
      repeat (6) @(posedge clk);
      #1 check("R2 single edge", 32'(buf_rdy), 1);
      @(negedge clk) dev_clk = 1'b0;
      repeat (3) @(posedge clk);

      // R7: strobe with empty register and load while full
      @(negedge clk) begin dir_out = 1'b1; odd_sel = 1'b0; end
      load(6'h2A);
      strobe(1'b0);
      strobe(1'b0);
      check("R7 empty strobe", 32'(out_data), 32'h2A);
      load(6'h11);
      load(6'h22);
      strobe(1'b0);
      check("R7 load while full", 32'(out_data), 32'h11);

      // R8/R9: last character disconnects
      load(6'h3F);
      @(negedge clk) last_chr = 1'b1;
      strobe(1'b0);
      @(negedge clk) last_chr = 1'b0;
      #1 check("R8 disc set", 32'(disc), 1);
      check("R9 lines low", {25'(out_data), out_par}, 0);
      check("R9 not ready", 32'(buf_rdy), 0);
      load(6'h05);
      #1 check("R9 load ignored", 32'(buf_rdy), 0);
      one_shot(rec_begin);
      #1 check("R9 rec clears", 32'(disc), 0);
      check("R9 hold empty", 32'(buf_rdy), 1);

      // R8 in receive mode, then R1 start clears
      @(negedge clk) begin dir_out = 1'b0; last_chr = 1'b1; in_data = 6'h09; end
      strobe(1'b1);
      @(negedge clk) last_chr = 1'b0;
      #1 check("R8 rx disc", 32'(disc), 1);
      @(negedge clk) in_data = 6'h30;
      strobe(1'b0);
      check("R9 rx ignored", 32'(rx_char), 32'h09);
      one_shot(start);
      #1 check("R1 start disc", 32'(disc), 0);
      check("R1 start rdy", 32'(buf_rdy), 1);
      check("R1 start out", {25'(out_data), out_par}, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule